// File: doc/BRIEF.md
# Serial Control Register Access Master

This block lets on-chip logic read and write the 16-bit control registers of an external audio decoder over a bit-serial control port. A host raises a one-cycle request carrying a read/write flag, an 8-bit register address and, for writes, a 16-bit word. The block then runs one complete frame on the serial lines and returns a one-cycle completion pulse. After a read, the captured word is on the read-data output.

Every frame is 32 serial clocks long. The first byte is an opcode, 8'h02 for a write or 8'h03 for a read; both values are parameters. The second byte is the register address. The last 16 clocks either carry the write word out or bring the read word in, high byte first. A programmable divider sets the serial clock. Each high phase and each low phase lasts HALF_DIV system clock cycles, with a minimum of 1.

Top module: `ser_ctl_master`

## Requirements
- R1: After reset, csN is 1, sclk is 0, busy is 0, done is 0 and rdData is 16'h0000.
- R2: A write request sends the 32-bit frame {8'h02, address, data} on mosi, most significant bit first. The bit for frame position 31 is sampled on the first rising sclk edge after csN falls.
- R3: A read request sends {8'h03, address} and holds mosi at 0 during the following 16 clocks. rdData then holds the 16 bits seen on miso, first bit in bit 15. The slave drives each of those bits after a falling sclk edge, and the master samples it at the end of the next high phase.
- R4: csN stays low without a break from the cycle after the request is accepted until the final falling sclk edge. Exactly 32 rising sclk edges occur in that time.
- R5: sclk is 0 whenever csN is 1, so the clock idles low between transactions.
- R6: mosi never changes at a rising sclk edge. It changes only when a frame is loaded or at a falling edge.
- R7: Inside a transaction, every high phase and every low phase of sclk lasts exactly HALF_DIV system clock cycles. This includes the low phase from csN falling to the first rise.
- R8: done is a one-cycle pulse in the cycle where csN has just returned to 1. After a read, rdData is valid in that cycle.
- R9: busy is 1 from the cycle after acceptance until the cycle after csN rises. A request presented while busy is 1 is ignored and starts no frame.
- R10: A write transaction leaves rdData unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when busy is 0 |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqAddr | input | 8 | Register address |
| reqWData | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Last word read |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |

## Verification
Two situations are hardest to reach from the ports. The first is the read-data alignment: the slave changes miso only after a falling edge, while the master samples late in the high phase. The bench slave model drives miso only at falling sclk edges, and it computes its reply from the address it decoded off mosi. A wrong bit index or a capture on the wrong edge therefore shows up as a wrong word. The second is a request that arrives in the middle of a frame, which the bench injects partway through a transaction before checking that the frame is intact and that no second frame follows.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_FIN  = 2'd3
  } ctlState_t;

  typedef struct packed {
    logic load;     // start a frame: load shifter, drop chip select
    logic rise;     // serial clock goes high
    logic fall;     // serial clock goes low, transmit shifter advances
    logic capture;  // sample miso into the receive shifter
    logic latch;    // publish the received word
    logic release_; // chip select back high
  } ctlStrobe_t;

endpackage

// File: rtl/ser_ctl_fsm.sv
module ser_ctl_fsm
  import ser_ctl_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int FRAME_W  = 32,
  parameter int DATA_W   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqRead,
  output ctlStrobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int DIV_W     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W     = $clog2(FRAME_W);
  localparam int CAP_START = FRAME_W - DATA_W;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] BIT_CAP  = BIT_W'(CAP_START);

  ctlState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitIdx;
  logic              isRead;
  logic              halfDone;
  logic              lastBit;

  assign halfDone = (divCnt == DIV_LAST);
  assign lastBit  = (bitIdx == BIT_LAST);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE: strb.load = reqValid;
      ST_LOW:  strb.rise = halfDone;
      ST_HIGH: begin
        if (halfDone) begin
          strb.fall     = 1'b1;
          strb.capture  = isRead && (bitIdx >= BIT_CAP);
          strb.release_ = lastBit;
          strb.latch    = lastBit && isRead;
        end
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      isRead <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= ST_LOW;
            isRead <= reqRead;
            divCnt <= '0;
            bitIdx <= '0;
          end
        end
        ST_LOW: begin
          if (halfDone) begin
            divCnt <= '0;
            state  <= ST_HIGH;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (halfDone) begin
            divCnt <= '0;
            if (lastBit) begin
              state <= ST_FIN;
              done  <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              state  <= ST_LOW;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ser_ctl_dp.sv
module ser_ctl_dp
  import ser_ctl_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 16,
  parameter int          OP_W   = 8,
  parameter logic [7:0]  OP_WR  = 8'h02,
  parameter logic [7:0]  OP_RD  = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic              miso,
  output logic              csN,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rdData
);

  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;

  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;
  logic [OP_W-1:0]    opSel;
  logic [DATA_W-1:0]  wordSel;

  assign opSel   = reqRead ? OP_W'(OP_RD) : OP_W'(OP_WR);
  assign wordSel = reqRead ? '0 : reqWData;
  assign mosi    = txShift[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
      csN     <= 1'b1;
      sclk    <= 1'b0;
    end else begin
      if (strb.load) begin
        txShift <= {opSel, reqAddr, wordSel};
        csN     <= 1'b0;
        sclk    <= 1'b0;
      end
      if (strb.rise) sclk <= 1'b1;
      if (strb.fall) begin
        sclk    <= 1'b0;
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
      if (strb.capture) rxShift <= {rxShift[DATA_W-2:0], miso};
      if (strb.latch)   rdData  <= {rxShift[DATA_W-2:0], miso};
      if (strb.release_) csN    <= 1'b1;
    end
  end

endmodule

// File: rtl/ser_ctl_master.sv
module ser_ctl_master
  import ser_ctl_pkg::*;
#(
  parameter int         HALF_DIV = 2,
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 16,
  parameter logic [7:0] OP_WR    = 8'h02,
  parameter logic [7:0] OP_RD    = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              csN,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  localparam int OP_W    = 8;
  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;

  ctlStrobe_t strb;

  ser_ctl_fsm #(
    .HALF_DIV(HALF_DIV),
    .FRAME_W (FRAME_W),
    .DATA_W  (DATA_W)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqRead (reqRead),
    .strb    (strb),
    .busy    (busy),
    .done    (done)
  );

  ser_ctl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OP_W  (OP_W),
    .OP_WR (OP_WR),
    .OP_RD (OP_RD)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqRead (reqRead),
    .reqAddr (reqAddr),
    .reqWData(reqWData),
    .miso    (miso),
    .csN     (csN),
    .sclk    (sclk),
    .mosi    (mosi),
    .rdData  (rdData)
  );

endmodule

// File: rtl/ser_ctl_checker.sv
module ser_ctl_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic csN,
  input logic sclk,
  input logic mosi
);

  // R5: clock low whenever deselected
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R6: data line holds across each rising clock edge
  a_r6_setup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(mosi));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: completion coincides with chip select just released
  a_r8_done_cs: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(csN));

  // R9: selected implies busy
  a_r9_busy_cs: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  // R9: busy clears the cycle after chip select rises
  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> !busy);

  // R4: chip select low during the whole busy window except the final cycle
  a_r4_cs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |-> !csN);

endmodule

bind ser_ctl_master ser_ctl_checker uChk (
  .clk (clk),
  .rstN(rstN),
  .busy(busy),
  .done(done),
  .csN (csN),
  .sclk(sclk),
  .mosi(mosi)
);

// File: tb/ser_ctl_master_test.sv
`timescale 1ns/1ps
module ser_ctl_master_test;

  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqRead = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [15:0] reqWData = '0;
  logic        busy, done, csN, sclk, mosi;
  logic        miso = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ser_ctl_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqWData(reqWData), .busy(busy), .done(done),
    .rdData(rdData), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // ---------------- slave model ----------------
  logic [31:0] rxFrame = '0;
  int          riseCnt = 0;
  logic [7:0]  slvAddr = '0;

  function automatic logic [15:0] respFor(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  always @(negedge csN) begin
    riseCnt = 0;
    rxFrame = '0;
  end

  always @(posedge sclk) begin
    if (!csN) begin
      rxFrame = {rxFrame[30:0], mosi};
      riseCnt = riseCnt + 1;
      if (riseCnt == 16) slvAddr = rxFrame[7:0];
    end
  end

  always @(negedge sclk) begin
    if (!csN && riseCnt >= 16 && riseCnt < 32) begin
      logic [15:0] r;
      r = respFor(slvAddr);
      miso = r[31 - riseCnt];
    end
  end

  // ---------------- phase / idle monitors ----------------
  int   hiLen = 0, loLen = 0, phaseBad = 0, idleBad = 0;
  logic prevS = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (csN && sclk) idleBad++;
      if (sclk && !prevS) begin
        if (loLen != HALF) phaseBad++;
        loLen = 0; hiLen = 1;
      end else if (sclk) begin
        hiLen++;
      end else if (prevS) begin
        if (hiLen != HALF) phaseBad++;
        hiLen = 0; loLen = csN ? 0 : 1;
      end else if (!csN) begin
        loLen++;
      end else begin
        loLen = 0;
      end
      prevS = sclk;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Runs one transaction; optionally injects a foreign request mid-frame.
  task automatic xfer(input logic rd, input logic [7:0] a, input logic [15:0] w,
                      input logic inject);
    int cyc;
    logic [15:0] prevRd;
    prevRd = rdData;
    @(negedge clk);
    reqValid = 1'b1; reqRead = rd; reqAddr = a; reqWData = w;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 busy after accept", {31'b0, busy}, 32'd1);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 40) begin
        reqValid = 1'b1; reqRead = ~rd; reqAddr = ~a; reqWData = ~w;
      end
      if (inject && cyc == 41) reqValid = 1'b0;
    end
    check("R8 done seen", {31'b0, done}, 32'd1);
    check("R8 csN high at done", {31'b0, csN}, 32'd1);
    check("R4 rise count", riseCnt, 32'd32);
    if (rd) begin
      check("R3 read frame", rxFrame, {8'h03, a, 16'h0000});
      check("R3 read data", {16'b0, rdData}, {16'b0, respFor(a)});
    end else begin
      check("R2 R6 write frame", rxFrame, {8'h02, a, w});
      check("R10 rdData kept", {16'b0, rdData}, {16'b0, prevRd});
    end
    @(negedge clk);
    check("R9 busy released", {31'b0, busy}, 32'd0);
    check("R8 done one cycle", {31'b0, done}, 32'd0);
    if (inject) begin
      repeat (2) @(negedge clk);
      check("R9 ignored request", {31'b0, csN}, 32'd1);
    end
    check("R7 phase lengths", phaseBad, 32'd0);
    check("R5 idle clock low", idleBad, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 csN", {31'b0, csN}, 32'd1);
    check("R1 sclk", {31'b0, sclk}, 32'd0);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 rdData", {16'b0, rdData}, 32'd0);

    // corner cases
    xfer(1'b0, 8'h00, 16'h0000, 1'b0);
    xfer(1'b0, 8'hFF, 16'hFFFF, 1'b0);
    xfer(1'b0, 8'h80, 16'h8001, 1'b0);
    xfer(1'b1, 8'h00, 16'h0000, 1'b0);
    xfer(1'b1, 8'hFF, 16'h0000, 1'b0);
    xfer(1'b0, 8'h3C, 16'h1234, 1'b0);   // R10 after a read
    xfer(1'b0, 8'h11, 16'hBEEF, 1'b1);   // R9 injection during write
    xfer(1'b1, 8'h42, 16'h0000, 1'b1);   // R9 injection during read

    // sweep over addresses with arithmetic data
    for (int i = 0; i < 48; i++) begin
      xfer(1'b0, 8'(i * 5 + 3), 16'(i * 16'h0101) ^ 16'hA5C3, 1'b0);
      xfer(1'b1, 8'(i * 5 + 3) ^ 8'h96, 16'h0000, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule